// File: doc/BRIEF.md
# Three-Wire Handshake Link Controller

This block is the host end of a byte-serial link to a small peripheral controller. An external shift register moves the bytes. The controller sets the shift direction, loads outgoing bytes, reads incoming ones and watches a per-byte completion strobe. Three handshake lines pace each transfer:

- `tip_n` (host-driven, active low) marks a transfer in progress.
- `tack` (host-driven) acknowledges a byte each time it changes level.
- `treq_n` (peripheral-driven, active low) asks for a transfer.

The peripheral can push packets of any length. The host collects them into a receive buffer and hands each complete packet over with its length. A packet can follow the previous one at once, without going back to idle.

In the other direction, the host queues one command packet at a time. The controller starts it only when the link is idle and the peripheral is not requesting. If the peripheral starts a transfer at the same moment (a collision), the controller abandons the send and keeps the packet queued. It retries once the request line is released.

Top module: `hsl_link_ctrl`

## Requirements
- R1: After reset the controller idles in the listen state: `tip_n`=1, `tack`=1, `sr_dir_out`=0, `tx_busy`=0 and `rx_valid`=0.
- R2: In listen, a byte-done event with `treq_n` low drives `tip_n` low and starts reception. With `treq_n` high and nothing queued, the event changes no output.
- R3: During reception, each byte-done event stores `sr_din` and pulses `sr_rd`. If `treq_n` is still low, `tack` toggles. If `treq_n` is high, that byte is the last one: `tack` and `tip_n` both go high.
- R4: The next byte-done event after the last byte delivers the packet. `rx_valid` pulses for one cycle, `rx_len` gives the byte count, and byte k sits at `rx_data[8k+7:8k]`. If `treq_n` is low at that event, reception of a chained packet starts at once with `tip_n` low. Otherwise the controller returns to listen.
- R5: The receive buffer holds RX_BYTES (16) bytes. Later bytes of the same packet are dropped, `rx_len` stays at 16, and `tack` keeps toggling for each byte.
- R6: A send starts only from listen, with a packet queued, `treq_n` high and no byte-done event in that cycle. At the start, `sr_dir_out` goes to 1, byte 0 of the packet is written (an `sr_wr` pulse with the byte on `sr_dout`), and `tip_n` goes low.
- R7: If `treq_n` is low at the first byte-done event of a send, that is a collision. The controller sets `sr_dir_out`=0, pulses `sr_rd`, drives `tip_n` and `tack` high, returns to listen and keeps `tx_busy`=1. It restarts the send from byte 0 once `treq_n` is high again.
- R8: A successful first event writes byte 1 and toggles `tack`. Each later event writes the next byte in order and toggles `tack`, up to byte `tx_len`-1.
- R9: The byte-done event after the last byte ends the send. `tx_busy` clears, `sr_dir_out` goes to 0, `sr_rd` pulses, `tip_n` and `tack` go high, and the controller returns to listen.
- R10: `tx_req` with `tx_data`/`tx_len` is accepted only while `tx_busy`=0. Byte k sits at `tx_data[8k+7:8k]`. A request made while busy is ignored. `tx_busy` stays 1 from acceptance until the send completes.
- R11: `treq_n` and `sr_done` each pass through a two-flop synchronizer. A byte-done event is the rising edge of `sr_done`, so a strobe held high for several cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_din | input | 8 | Byte read from the shift register |
| sr_done | input | 1 | Byte-done strobe from the shift register (rising edge counts) |
| sr_dout | output | 8 | Byte to load into the shift register |
| sr_wr | output | 1 | One-cycle load strobe for `sr_dout` |
| sr_rd | output | 1 | One-cycle read strobe (data reads and dummy reads) |
| sr_dir_out | output | 1 | Shift direction, 1 = host to peripheral |
| treq_n | input | 1 | Peripheral transfer request, active low |
| tip_n | output | 1 | Transfer in progress, active low |
| tack | output | 1 | Byte acknowledge, toggled per byte |
| tx_req | input | 1 | Offer a packet for sending |
| tx_data | input | 64 | Packet bytes, byte k at [8k+7:8k] |
| tx_len | input | 4 | Packet length in bytes (2..TX_BYTES) |
| tx_busy | output | 1 | A packet is queued or being sent |
| rx_valid | output | 1 | One-cycle pulse: a received packet is on `rx_data` |
| rx_data | output | 128 | Received bytes, byte k at [8k+7:8k] |
| rx_len | output | 5 | Number of bytes received (at most 16) |

## Verification
Reception is driven with a short packet that ends normally, two packets chained across the receive-end event, and an 18-byte packet that overflows the buffer. Together these separate a normal return to listen, an immediate restart and byte dropping. Sending is driven once without interference and once with the request line pulled low during the first byte. Comparing the logged `sr_wr` bytes, the `sr_rd` count and `tx_busy` distinguishes completion from collision and retry. A second request made while busy, an idle event with the request line high, and a byte-done strobe held for many cycles show which inputs must have no effect.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  typedef enum logic [2:0] {
    ST_LISTEN     = 3'd0,
    ST_RECV       = 3'd1,
    ST_RECV_END   = 3'd2,
    ST_SEND_START = 3'd3,
    ST_SEND       = 3'd4
  } link_state_e;
endpackage

// File: rtl/hsl_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
module hsl_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= RST_VAL;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsl_tx_queue.sv
// Holds one pending command packet until the controller finishes it.
module hsl_tx_queue #(
  parameter int TX_BYTES = 8,
  parameter int LEN_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic [TX_BYTES*8-1:0] data,
  input  logic [LEN_W-1:0]      len,
  input  logic                  clr,
  input  logic [CNT_W-1:0]      rd_idx,
  output logic [7:0]            rd_byte,
  output logic [CNT_W-1:0]      pend_len,
  output logic                  busy
);
  localparam int TAW = (TX_BYTES > 1) ? $clog2(TX_BYTES) : 1;
  localparam logic [CNT_W-1:0] TX_LIM = CNT_W'(TX_BYTES);

  logic [7:0] tbuf [TX_BYTES];
  logic       accept;

  assign busy   = (pend_len != '0);
  assign accept = req && !busy;

  always_ff @(posedge clk) begin
    if (rst)           pend_len <= '0;
    else if (clr)      pend_len <= '0;
    else if (accept)   pend_len <= CNT_W'(len);
  end

  for (genvar k = 0; k < TX_BYTES; k++) begin : g_load
    always_ff @(posedge clk) begin
      if (accept) tbuf[k] <= data[8*k +: 8];
    end
  end

  assign rd_byte = (rd_idx < TX_LIM) ? tbuf[rd_idx[TAW-1:0]] : 8'h00;

  // A queued packet stays unchanged until the controller clears it.
  p_pending_held_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr) |=> (pend_len == $past(pend_len)));
endmodule

// File: rtl/hsl_rx_store.sv
// Receive buffer (RAM-style write port) plus delivered-packet registers.
module hsl_rx_store #(
  parameter int RX_BYTES = 16,
  parameter int CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [CNT_W-1:0]      waddr,
  input  logic [7:0]            wdata,
  input  logic                  deliver,
  input  logic [CNT_W-1:0]      dlen,
  output logic                  rx_valid,
  output logic [RX_BYTES*8-1:0] rx_data,
  output logic [CNT_W-1:0]      rx_len
);
  localparam int AW = (RX_BYTES > 1) ? $clog2(RX_BYTES) : 1;

  logic [7:0] mem [RX_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_len   <= '0;
    end else begin
      rx_valid <= deliver;
      if (deliver) rx_len <= dlen;
    end
  end

  for (genvar k = 0; k < RX_BYTES; k++) begin : g_snap
    always_ff @(posedge clk) begin
      if (deliver) rx_data[8*k +: 8] <= mem[k];
    end
  end

  // Deliveries come one per byte-done edge, so they never run back to back.
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/hsl_fsm.sv
// Five-state handshake engine.
module hsl_fsm
  import hsl_pkg::*;
#(
  parameter int RX_BYTES = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic             treq_low,
  input  logic [7:0]       sr_din,
  input  logic [CNT_W-1:0] pend_len,
  input  logic [7:0]       tx_byte,
  output logic [CNT_W-1:0] tx_idx,
  output logic             tx_clr,
  output logic [7:0]       sr_dout,
  output logic             sr_wr,
  output logic             sr_rd,
  output logic             sr_dir_out,
  output logic             tip_n,
  output logic             tack,
  output logic             rx_we,
  output logic [CNT_W-1:0] rx_waddr,
  output logic [7:0]       rx_wdata,
  output logic             rx_deliver,
  output logic [CNT_W-1:0] rx_dlen
);
  localparam logic [CNT_W-1:0] RX_LIM = CNT_W'(RX_BYTES);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO    = CNT_W'(2);

  link_state_e      state;
  logic [CNT_W-1:0] idx;
  logic             send_done;

  // Byte fetch index: 0 when starting, 1 in send-start, running index later.
  always_comb begin
    unique case (state)
      ST_SEND_START: tx_idx = ONE;
      ST_SEND:       tx_idx = idx;
      default:       tx_idx = '0;
    endcase
  end

  assign send_done  = (state == ST_SEND) && ev && !(idx < pend_len);
  assign tx_clr     = send_done;
  assign rx_we      = (state == ST_RECV) && ev && (idx < RX_LIM);
  assign rx_waddr   = idx;
  assign rx_wdata   = sr_din;
  assign rx_deliver = (state == ST_RECV_END) && ev;
  assign rx_dlen    = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_LISTEN;
      idx        <= '0;
      tip_n      <= 1'b1;
      tack       <= 1'b1;
      sr_dir_out <= 1'b0;
      sr_dout    <= 8'h00;
      sr_wr      <= 1'b0;
      sr_rd      <= 1'b0;
    end else begin
      sr_wr <= 1'b0;
      sr_rd <= 1'b0;
      unique case (state)
        ST_LISTEN: begin
          if (ev) begin
            if (treq_low) begin
              tip_n <= 1'b0;
              state <= ST_RECV;
            end
          end else if (pend_len != '0 && !treq_low) begin
            sr_dir_out <= 1'b1;
            sr_dout    <= tx_byte;
            sr_wr      <= 1'b1;
            tip_n      <= 1'b0;
            state      <= ST_SEND_START;
          end
        end
        ST_RECV: begin
          if (ev) begin
            sr_rd <= 1'b1;
            if (idx < RX_LIM) idx <= idx + ONE;
            if (treq_low) begin
              tack <= ~tack;
            end else begin
              tack  <= 1'b1;
              tip_n <= 1'b1;
              state <= ST_RECV_END;
            end
          end
        end
        ST_RECV_END: begin
          if (ev) begin
            idx <= '0;
            if (treq_low) begin
              tip_n <= 1'b0;
              state <= ST_RECV;
            end else begin
              state <= ST_LISTEN;
            end
          end
        end
        ST_SEND_START: begin
          if (ev) begin
            if (treq_low) begin
              sr_dir_out <= 1'b0;
              sr_rd      <= 1'b1;
              tip_n      <= 1'b1;
              tack       <= 1'b1;
              state      <= ST_LISTEN;
            end else begin
              sr_dout <= tx_byte;
              sr_wr   <= 1'b1;
              tack    <= ~tack;
              idx     <= TWO;
              state   <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (ev) begin
            if (idx < pend_len) begin
              sr_dout <= tx_byte;
              sr_wr   <= 1'b1;
              tack    <= ~tack;
              idx     <= idx + ONE;
            end else begin
              idx        <= '0;
              sr_dir_out <= 1'b0;
              sr_rd      <= 1'b1;
              tip_n      <= 1'b1;
              tack       <= 1'b1;
              state      <= ST_LISTEN;
            end
          end
        end
        default: state <= ST_LISTEN;
      endcase
    end
  end

  // A transfer is only ever active with tip_n held low.
  p_tip_low_active_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV || state == ST_SEND_START || state == ST_SEND) |-> !tip_n);
  // Shift direction follows the kind of transfer in progress.
  p_dir_send_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND_START || state == ST_SEND) |-> sr_dir_out);
  p_dir_recv_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV || state == ST_RECV_END) |-> !sr_dir_out);
  // Buffer index never runs past the receive buffer.
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV || state == ST_RECV_END) |-> (idx <= RX_LIM));
  // A collision backs off to listen with both host lines released.
  p_collision_backoff_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND_START && ev && treq_low) |=>
      (state == ST_LISTEN && tip_n && tack && !sr_dir_out));
  // Load and read strobes are never issued together.
  p_wr_rd_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(sr_wr && sr_rd));
endmodule

// File: rtl/hsl_link_ctrl.sv
module hsl_link_ctrl #(
  parameter int RX_BYTES = 16,
  parameter int TX_BYTES = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(((RX_BYTES > TX_BYTES) ? RX_BYTES : TX_BYTES) + 1),
  localparam int LEN_W = $clog2(TX_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            sr_din,
  input  logic                  sr_done,
  output logic [7:0]            sr_dout,
  output logic                  sr_wr,
  output logic                  sr_rd,
  output logic                  sr_dir_out,
  input  logic                  treq_n,
  output logic                  tip_n,
  output logic                  tack,
  input  logic                  tx_req,
  input  logic [TX_BYTES*8-1:0] tx_data,
  input  logic [LEN_W-1:0]      tx_len,
  output logic                  tx_busy,
  output logic                  rx_valid,
  output logic [RX_BYTES*8-1:0] rx_data,
  output logic [CNT_W-1:0]      rx_len
);
  logic [1:0]       sync_q;
  logic             done_s, done_q, ev, treq_low;
  logic [CNT_W-1:0] pend_len, tx_idx, rx_waddr, rx_dlen;
  logic [7:0]       tx_byte, rx_wdata;
  logic             tx_clr, rx_we, rx_deliver;

  hsl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .d({sr_done, treq_n}), .q(sync_q)
  );

  assign done_s   = sync_q[1];
  assign treq_low = !sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= done_s;
  end

  assign ev = done_s && !done_q;

  hsl_tx_queue #(.TX_BYTES(TX_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst(rst), .req(tx_req), .data(tx_data), .len(tx_len),
    .clr(tx_clr), .rd_idx(tx_idx), .rd_byte(tx_byte),
    .pend_len(pend_len), .busy(tx_busy)
  );

  hsl_rx_store #(.RX_BYTES(RX_BYTES), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
    .deliver(rx_deliver), .dlen(rx_dlen),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_len(rx_len)
  );

  hsl_fsm #(.RX_BYTES(RX_BYTES), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .ev(ev), .treq_low(treq_low), .sr_din(sr_din),
    .pend_len(pend_len), .tx_byte(tx_byte), .tx_idx(tx_idx), .tx_clr(tx_clr),
    .sr_dout(sr_dout), .sr_wr(sr_wr), .sr_rd(sr_rd), .sr_dir_out(sr_dir_out),
    .tip_n(tip_n), .tack(tack), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .rx_wdata(rx_wdata), .rx_deliver(rx_deliver), .rx_dlen(rx_dlen)
  );

  // The edge detector yields single-cycle events however long sr_done is held.
  p_single_event_r11: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);
endmodule

// File: tb/hsl_link_ctrl_tb_top.sv
`timescale 1ns/1ps
module hsl_link_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic [7:0]   sr_din;
  logic         sr_done;
  logic [7:0]   sr_dout;
  logic         sr_wr, sr_rd, sr_dir_out;
  logic         treq_n;
  logic         tip_n, tack;
  logic         tx_req;
  logic [63:0]  tx_data;
  logic [3:0]   tx_len;
  logic         tx_busy;
  logic         rx_valid;
  logic [127:0] rx_data;
  logic [4:0]   rx_len;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int rx_cnt = 0;
  logic [7:0]   wr_log [64];
  logic [127:0] last_rx;
  logic [4:0]   last_len;

  always #4 clk = ~clk;

  hsl_link_ctrl dut_i (
    .clk(clk), .rst(rst), .sr_din(sr_din), .sr_done(sr_done),
    .sr_dout(sr_dout), .sr_wr(sr_wr), .sr_rd(sr_rd), .sr_dir_out(sr_dir_out),
    .treq_n(treq_n), .tip_n(tip_n), .tack(tack),
    .tx_req(tx_req), .tx_data(tx_data), .tx_len(tx_len), .tx_busy(tx_busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_len(rx_len)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (sr_wr) begin
        if (wr_cnt < 64) wr_log[wr_cnt] = sr_dout;
        wr_cnt++;
      end
      if (sr_rd) rd_cnt++;
      if (rx_valid) begin
        rx_cnt++;
        last_rx  = rx_data;
        last_len = rx_len;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic byte_ev(input logic [7:0] b, input int hold = 3);
    sr_din  = b;
    sr_done = 1'b1;
    repeat (hold) @(negedge clk);
    sr_done = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic set_treq(input logic v);
    treq_n = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(tip_n == 1'b1 && tack == 1'b1, "R1 handshake idle", {tip_n, tack}, 2'b11);
    check(sr_dir_out == 1'b0 && tx_busy == 1'b0, "R1 dir/busy", {sr_dir_out, tx_busy}, 0);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
  endtask

  task automatic t_idle_event;
    int w = wr_cnt;
    byte_ev(8'h5A);
    check(tip_n == 1'b1 && tack == 1'b1 && w == wr_cnt, "R2 idle event ignored",
          {tip_n, tack}, 2'b11);
  endtask

  task automatic t_rx_basic;
    int c = rx_cnt;
    int r = rd_cnt;
    set_treq(1'b0);
    byte_ev(8'h00);
    check(tip_n == 1'b0, "R2 reception start", tip_n, 0);
    byte_ev(8'hA1);
    check(tack == 1'b0, "R3 tack toggle 1", tack, 0);
    byte_ev(8'hB2);
    check(tack == 1'b1, "R3 tack toggle 2", tack, 1);
    set_treq(1'b1);
    byte_ev(8'hC3);
    check(tip_n == 1'b1 && tack == 1'b1, "R3 last byte releases", {tip_n, tack}, 2'b11);
    check(rd_cnt == r + 3, "R3 read strobes", rd_cnt - r, 3);
    byte_ev(8'h00);
    check(rx_cnt == c + 1, "R4 one delivery", rx_cnt - c, 1);
    check(last_len == 5'd3, "R4 length", last_len, 3);
    check(last_rx[23:0] == 24'hC3B2A1, "R4 data", last_rx[23:0], 24'hC3B2A1);
    check(tip_n == 1'b1, "R4 back to listen", tip_n, 1);
  endtask

  task automatic t_rx_chain;
    int c = rx_cnt;
    set_treq(1'b0);
    byte_ev(8'h00);
    byte_ev(8'h11);
    set_treq(1'b1);
    byte_ev(8'h22);
    set_treq(1'b0);
    byte_ev(8'h00);
    check(rx_cnt == c + 1 && last_len == 5'd2 && last_rx[15:0] == 16'h2211,
          "R4 first chained packet", last_rx[15:0], 16'h2211);
    check(tip_n == 1'b0, "R4 chained restart", tip_n, 0);
    byte_ev(8'h33, 8);   // held strobe counts once
    set_treq(1'b1);
    byte_ev(8'h44);
    byte_ev(8'h00);
    check(rx_cnt == c + 2 && last_len == 5'd2, "R11 held strobe single byte", last_len, 2);
    check(last_rx[15:0] == 16'h4433, "R4 second chained packet", last_rx[15:0], 16'h4433);
    check(tip_n == 1'b1, "R4 listen after chain", tip_n, 1);
  endtask

  task automatic t_rx_overflow;
    bit ok = 1'b1;
    int toggles = 0;
    logic prev;
    set_treq(1'b0);
    byte_ev(8'h00);
    for (int i = 0; i < 17; i++) begin
      prev = tack;
      byte_ev(8'(i + 8'h40));
      if (tack != prev) toggles++;
    end
    set_treq(1'b1);
    byte_ev(8'hEE);
    byte_ev(8'h00);
    check(toggles == 17, "R5 handshake continues", toggles, 17);
    check(last_len == 5'd16, "R5 length saturates", last_len, 16);
    for (int k = 0; k < 16; k++)
      if (last_rx[8*k +: 8] != 8'(k + 8'h40)) ok = 1'b0;
    check(ok, "R5 first bytes kept", last_rx[7:0], 8'h40);
  endtask

  task automatic t_send;
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    logic prev;
    tx_data = 64'h0000_0000_00CC_BBAA;
    tx_len  = 4'd3;
    tx_req  = 1'b1;
    @(negedge clk);
    tx_req  = 1'b0;
    repeat (4) @(negedge clk);
    check(tx_busy && sr_dir_out && !tip_n, "R6 send start lines",
          {tx_busy, sr_dir_out, tip_n}, 3'b110);
    check(wr_cnt == w0 + 1 && wr_log[w0] == 8'hAA, "R6 byte 0", wr_log[w0], 8'hAA);
    tx_data = 64'h0000_0000_0000_7777;
    tx_len  = 4'd2;
    tx_req  = 1'b1;
    @(negedge clk);
    tx_req  = 1'b0;
    prev = tack;
    byte_ev(8'h00);
    check(wr_log[w0 + 1] == 8'hBB && tack != prev, "R8 byte 1", wr_log[w0 + 1], 8'hBB);
    byte_ev(8'h00);
    check(wr_log[w0 + 2] == 8'hCC, "R8 byte 2", wr_log[w0 + 2], 8'hCC);
    byte_ev(8'h00);
    check(!tx_busy && !sr_dir_out && tip_n && tack, "R9 end of send",
          {tx_busy, sr_dir_out, tip_n, tack}, 4'b0011);
    check(rd_cnt == r0 + 1, "R9 dummy read", rd_cnt - r0, 1);
    check(wr_cnt == w0 + 3, "R10 busy request ignored", wr_cnt - w0, 3);
  endtask

  task automatic t_collision;
    int w0 = wr_cnt;
    int r0;
    tx_data = 64'h0000_0000_0000_D2D1;
    tx_len  = 4'd2;
    tx_req  = 1'b1;
    @(negedge clk);
    tx_req  = 1'b0;
    repeat (4) @(negedge clk);
    check(wr_cnt == w0 + 1 && wr_log[w0] == 8'hD1, "R10 accepted when idle", wr_log[w0], 8'hD1);
    set_treq(1'b0);
    r0 = rd_cnt;
    byte_ev(8'h00);
    check(!sr_dir_out && tip_n && tack && tx_busy, "R7 collision backoff",
          {sr_dir_out, tip_n, tack, tx_busy}, 4'b0111);
    check(rd_cnt == r0 + 1, "R7 dummy read", rd_cnt - r0, 1);
    repeat (10) @(negedge clk);
    check(wr_cnt == w0 + 1, "R6 no start while requested", wr_cnt - w0, 1);
    set_treq(1'b1);
    check(wr_cnt == w0 + 2 && wr_log[w0 + 1] == 8'hD1 && !tip_n, "R7 retry from byte 0",
          wr_log[w0 + 1], 8'hD1);
    byte_ev(8'h00);
    check(wr_log[w0 + 2] == 8'hD2, "R8 retry byte 1", wr_log[w0 + 2], 8'hD2);
    byte_ev(8'h00);
    check(!tx_busy && tip_n, "R9 retry completes", {tx_busy, tip_n}, 2'b01);
  endtask

  initial begin
    rst = 1'b1; sr_din = 8'h00; sr_done = 1'b0; treq_n = 1'b1;
    tx_req = 1'b0; tx_data = '0; tx_len = '0;
    @(negedge clk);
    t_reset();
    t_idle_event();
    t_rx_basic();
    t_rx_chain();
    t_rx_overflow();
    t_send();
    t_collision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule